// File: doc/BRIEF.md
# Flash chip-erase command sequence decoder

This block is the write-side command interpreter of a byte-wide flash memory. It watches the host's write strobe, takes the address and data byte of each completed write, and follows the six-write chip-erase sequence. The sequence is two unlock writes, an erase set-up write, two more unlock writes and a confirm write. When the sequence is accepted, the block sends a one-cycle start pulse to the erase engine and switches the read path from array data to status data.

If a sequence that has already started is broken by a wrong write, the block raises a one-cycle abort indication and returns to array-read mode. While the erase is running, all writes are ignored. After the engine reports completion, status reads stay selected until the host writes the reset byte. The write strobe is treated as asynchronous. It is registered, and each write is taken at its rising edge.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, read_status, erase_start and abort are all 0.
- R2: A write is taken on the first clock edge at which we_n is 1 and the registered copy of we_n from the previous edge is 0. addr and din are sampled at that edge, and the outputs reflect the write right after it. A strobe held low has no effect, and a strobe held high for several cycles counts as one write.
- R3: Six writes in a row start the erase: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. After the sixth write, erase_start is 1 for exactly one cycle and read_status becomes 1.
- R4: Only the low 11 address bits are compared against 555h and 2AAh. Upper address bits have no effect.
- R5: A write that does not match step 2 to 6 of the sequence makes abort 1 for exactly one cycle and leaves read_status at 0. The offending write is discarded, so a complete new six-write sequence is needed before any erase starts.
- R6: In array-read mode, a write that is not AAh@555h is ignored. It raises no abort and begins no sequence.
- R7: From the start pulse until erase_done is seen, every write is ignored. read_status stays 1, and erase_start and abort stay 0.
- R8: After erase_done, read_status stays 1 until a write of F0h to any address returns it to 0 on the edge that takes that write. Other writes in this state are ignored.
- R9: erase_done has no effect unless an erase is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_n | input | 1 | Active-low write strobe; a write completes on its rising edge |
| addr | input | ADDR_W | Write address |
| din | input | 8 | Write data byte |
| erase_done | input | 1 | Erase engine completion pulse |
| read_status | output | 1 | 1 = reads return status, 0 = array data |
| erase_start | output | 1 | One-cycle pulse that starts the erase engine |
| abort | output | 1 | One-cycle pulse when an entered sequence is broken |

## Verification
Every result of a write is due on the clock edge that sees the strobe's rising edge. That edge is one edge after the bench raises we_n, because the previous edge registered we_n as low. The bench raises we_n on a falling edge and compares erase_start, abort and read_status on the next falling edge against a reference model that steps once per write. It then checks on the following falling edge that both pulses are low again. A completion pulse on erase_done is checked one edge later through read_status.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W = 18,
  parameter int CMP_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              erase_done,
  output logic              read_status,
  output logic              erase_start,
  output logic              abort
);

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_SETUP, S_UNL2, S_UNL3, S_CONF, S_BUSY, S_DONE
  } st_t;

  localparam logic [CMP_W-1:0] A_HI = CMP_W'('h555);
  localparam logic [CMP_W-1:0] A_LO = CMP_W'('h2AA);

  st_t  state, nxt;
  logic we_q, rise, at_hi, at_lo, step_ok, start_n, abort_n;

  assign rise  = we_n & ~we_q;
  assign at_hi = addr[CMP_W-1:0] == A_HI;
  assign at_lo = addr[CMP_W-1:0] == A_LO;
  assign read_status = (state == S_BUSY) || (state == S_DONE);

  always_comb begin
    case (state)
      S_IDLE, S_UNL2: step_ok = at_hi && din == 8'hAA;
      S_UNL1, S_UNL3: step_ok = at_lo && din == 8'h55;
      S_SETUP:        step_ok = at_hi && din == 8'h80;
      S_CONF:         step_ok = at_hi && din == 8'h10;
      default:        step_ok = 1'b0;
    endcase
  end

  always_comb begin
    nxt = state;
    start_n = 1'b0;
    abort_n = 1'b0;
    case (state)
      S_BUSY: if (erase_done) nxt = S_DONE;
      S_DONE: if (rise && din == 8'hF0) nxt = S_IDLE;
      default:
        if (rise) begin
          if (step_ok) begin
            nxt = st_t'(state + 3'd1);
            start_n = (state == S_CONF);
          end else if (state != S_IDLE) begin
            nxt = S_IDLE;
            abort_n = 1'b1;
          end
        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      we_q        <= 1'b1;
      erase_start <= 1'b0;
      abort       <= 1'b0;
    end else begin
      state       <= nxt;
      we_q        <= we_n;
      erase_start <= start_n;
      abort       <= abort_n;
    end
  end

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
  assert_start_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> read_status);
  assert_abort_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
  assert_abort_array_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !read_status);
  assert_pulses_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({erase_start, abort}) <= 1);
  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY) |=> read_status && !erase_start && !abort);
  assert_exit_on_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE) && !(rise && din == 8'hF0) |=> read_status);
  assert_no_write_no_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rise && state != S_BUSY |=> $stable(read_status) && !erase_start && !abort);

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int AW = 18;

  logic clk = 0, rst_n = 0, we_n = 1, erase_done = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic read_status, erase_start, abort;

  int checks = 0, failures = 0;
  int m_st = 0;
  logic e_start, e_abort;

  always #2 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .CMP_W(11)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .din(din),
    .erase_done(erase_done), .read_status(read_status),
    .erase_start(erase_start), .abort(abort));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic bit step_ok(int s, logic [AW-1:0] a, logic [7:0] d);
    logic [10:0] lo = a[10:0];
    case (s)
      0, 3: return lo == 11'h555 && d == 8'hAA;
      1, 4: return lo == 11'h2AA && d == 8'h55;
      2:    return lo == 11'h555 && d == 8'h80;
      5:    return lo == 11'h555 && d == 8'h10;
      default: return 0;
    endcase
  endfunction

  function automatic int step_addr(int s);
    return (s == 1 || s == 4) ? 'h2AA : 'h555;
  endfunction

  function automatic logic [7:0] step_data(int s);
    case (s)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2: return 8'h80;
      default: return 8'h10;
    endcase
  endfunction

  task automatic model(logic [AW-1:0] a, logic [7:0] d);
    e_start = 0; e_abort = 0;
    if (m_st <= 5) begin
      if (step_ok(m_st, a, d)) begin
        m_st++;
        e_start = (m_st == 6);
      end else if (m_st > 0) begin
        e_abort = 1; m_st = 0;
      end
    end else if (m_st == 7 && d == 8'hF0) m_st = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, int hold, string req);
    @(negedge clk);
    addr = a; din = d; we_n = 0;
    repeat (hold) begin
      @(negedge clk);
      chk({req, " R2 low strobe"}, erase_start | abort, 1'b0);
    end
    we_n = 1;
    model(a, d);
    @(negedge clk);
    chk({req, " start"}, erase_start, e_start);
    chk({req, " abort"}, abort, e_abort);
    chk({req, " status"}, read_status, m_st >= 6);
    @(negedge clk);
    chk({req, " R2 single write"}, erase_start | abort, 1'b0);
    chk({req, " R2 status hold"}, read_status, m_st >= 6);
  endtask

  task automatic done_pulse(string req);
    @(negedge clk);
    erase_done = 1;
    @(negedge clk);
    erase_done = 0;
    if (m_st == 6) m_st = 7;
    chk(req, read_status, m_st >= 6);
  endtask

  task automatic full_seq(logic [6:0] hi, string req);
    for (int s = 0; s < 6; s++) wr({hi, 11'(step_addr(s))}, step_data(s), 1, req);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 status", read_status, 0);
    chk("R1 start", erase_start, 0);
    chk("R1 abort", abort, 0);
    rst_n = 1;

    wr(18'h00555, 8'h55, 1, "R6 wrong first");
    wr(18'h002AA, 8'hF0, 1, "R6 reset in idle");
    done_pulse("R9 done while idle");

    full_seq(7'h00, "R3 plain");
    wr(18'h00555, 8'hAA, 2, "R7 busy write");
    wr(18'h00555, 8'hF0, 1, "R7 busy reset");
    done_pulse("R8 done");
    wr(18'h00555, 8'h10, 1, "R8 non reset");
    done_pulse("R9 done again");
    wr(18'h3F123, 8'hF0, 1, "R8 reset any addr");

    full_seq(7'h5A, "R4 upper bits");
    done_pulse("R8 done2");
    wr(18'h00000, 8'hF0, 1, "R8 reset2");

    for (int k = 1; k < 6; k++) begin
      for (int s = 0; s < k; s++) wr(18'(step_addr(s)), step_data(s), 1, "R5 prefix");
      wr(18'h00555, 8'h00, 1, "R5 broken step");
    end
    for (int s = 0; s < 5; s++) wr(18'(step_addr(s)), step_data(s), 1, "R5 restart");
    wr(18'h00555, 8'h10, 4, "R2 held strobe confirm");
    done_pulse("R8 done3");
    wr(18'h00555, 8'hF0, 1, "R8 reset3");

    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      int r = $urandom_range(0, 99);
      a = 18'($urandom);
      d = 8'($urandom);
      if (m_st <= 5 && r < 75) begin
        a[10:0] = 11'(step_addr(m_st));
        d = step_data(m_st);
      end else if (r < 85) begin
        a[10:0] = ($urandom_range(0, 1) != 0) ? 11'h555 : 11'h2AA;
        case ($urandom_range(0, 4))
          0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'h80; 3: d = 8'h10; default: d = 8'hF0;
        endcase
      end
      if ((m_st >= 6 && $urandom_range(0, 3) == 0) || $urandom_range(0, 40) == 0)
        done_pulse("R9 random done");
      else
        wr(a, d, $urandom_range(1, 3), "R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule